// File: doc/BRIEF.md
# Wait-State Host Bus Slave with Shared RAM Arbitration

This block connects an asynchronous host processor to a shared 16-bit RAM and a small register file inside a larger chip. The host opens an access by pulling its strobe and select lines low and drives a memory/register choice, a read/write line, an address and, for writes, data. The block captures the host's control lines on a falling clock edge. On the following rising edge it captures the address, and it pulls the transfer-enable output low as soon as the internal RAM user is idle. It then counts a fixed number of wait states before it pulls the ready output low. At that point read data sits on the output data bus, or write data has been stored.

An internal requester shares the single RAM port. The internal requester wins any edge on which both sides want the RAM. Once the host holds transfer-enable, the internal requester is stalled until the host releases its strobe. A polarity input sets which level of the read/write line means read.

Top module: `hbus_wait_if`

## Requirements
- R1: After reset `hb_xfer_n` and `hb_ready_n` are 1 and `hb_rdata` is 0. With `int_req` low, `hb_xfer_n` goes low on the first rising clock edge that follows a falling edge at which both `hb_strobe_n` and `hb_select_n` were sampled low.
- R2: If strobe and select go low after a falling edge rather than before it, their capture moves to the next falling edge. `hb_xfer_n` therefore falls exactly one clock later, at the second rising edge after they went low instead of the first.
- R3: `hb_mem_nreg` = 1 selects the RAM and 0 selects the register file. The register file has `REG_COUNT` entries indexed by the low address bits (`hb_addr[2:0]` by default). The RAM is indexed by the address modulo `RAM_DEPTH`.
- R4: `hb_mem_nreg` and `hb_rw` are held from the falling edge that captured the request. Changes to them later in the transfer have no effect.
- R5: `hb_addr` is held from the rising edge after that falling edge. Changes to it later in the transfer have no effect.
- R6: A read is requested when `hb_rw` equals `hb_rw_pol`: with `hb_rw_pol` = 1 a high level reads, and with `hb_rw_pol` = 0 a low level reads. Any other level is a write.
- R7: `hb_ready_n` falls exactly `WAIT_STATES` rising edges after `hb_xfer_n` falls. On that edge the write is stored, or the read data appears on `hb_rdata`.
- R8: After `hb_strobe_n` returns high, `hb_xfer_n` and `hb_ready_n` both return to 1 on the first rising edge after a falling edge that sees strobe high. Releasing `hb_select_n` after `hb_xfer_n` falls does not disturb the transfer.
- R9: If `int_req` is high on the rising edge where a host request would start, the host waits. `hb_xfer_n` falls on the first rising edge at which `int_req` is low. Outside a host transfer, `int_gnt` follows `int_req`.
- R10: While `hb_xfer_n` is low, `int_gnt` is 0 and the internal requester cannot reach the RAM.
- R11: `hb_rdata` is 0 whenever `hb_xfer_n` is 1, during wait states, and for write transfers.
- R12: A granted internal write with `int_we` = 1 stores `int_wdata` at `int_addr`. After a granted internal read, `int_rdata` holds the RAM word one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hb_strobe_n | input | 1 | Host strobe, active low |
| hb_select_n | input | 1 | Host select, active low |
| hb_mem_nreg | input | 1 | 1 = RAM, 0 = register file |
| hb_rw | input | 1 | Host read/write line, sense set by hb_rw_pol |
| hb_rw_pol | input | 1 | Level of hb_rw that means read |
| hb_addr | input | ADDR_W | Host address |
| hb_wdata | input | DATA_W | Host write data |
| hb_rdata | output | DATA_W | Host read data, zero when not driving a read |
| hb_xfer_n | output | 1 | Transfer enable, active low |
| hb_ready_n | output | 1 | Ready, active low |
| int_req | input | 1 | Internal RAM request |
| int_we | input | 1 | Internal request is a write |
| int_addr | input | $clog2(RAM_DEPTH) | Internal RAM address |
| int_wdata | input | DATA_W | Internal write data |
| int_rdata | output | DATA_W | Internal read data, one clock after the grant |
| int_gnt | output | 1 | Internal request granted this cycle |

## Verification
The assertions assume a well-behaved host. It keeps strobe low until ready has fallen and does not re-open a transfer before transfer-enable has returned high. It also keeps its inputs clear of the clock edges, so the wait-state window and the release order can be checked as exact cycle counts. They also assume `WAIT_STATES` is at least 2, so the RAM read has a cycle to settle before ready falls. The stimulus changes host and internal inputs only 1 ns after a clock edge. It always waits for ready before releasing strobe, and it raises `int_req` only on whole-cycle boundaries. The one deliberate exception is the late-strobe case, which drives the request just after a falling edge to exercise the extra-cycle path.

// File: rtl/hbus_pkg.sv
package hbus_pkg;

  // Host transfer sequencer states
  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_PEND = 2'd1,
    SQ_WAIT = 2'd2,
    SQ_DONE = 2'd3
  } seq_state_t;

  // Control fields captured on the falling edge
  typedef struct packed {
    logic to_ram;
    logic is_read;
  } ctl_t;

endpackage

// File: rtl/hbus_ctl_latch.sv
module hbus_ctl_latch
  import hbus_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic strobe_n,
  input  logic select_n,
  input  logic mem_nreg,
  input  logic rw,
  input  logic rw_pol,
  output logic held,
  output ctl_t ctl
);

  // Falling-edge capture: the first falling edge with strobe and select low
  // freezes the access kind; strobe high (select ignored) ends the hold.
  always_ff @(negedge clk) begin
    if (rst) begin
      held <= 1'b0;
      ctl  <= '0;
    end else if (strobe_n) begin
      held <= 1'b0;
    end else if (!held && !select_n) begin
      held        <= 1'b1;
      ctl.to_ram  <= mem_nreg;
      ctl.is_read <= (rw == rw_pol);
    end
  end

endmodule

// File: rtl/hbus_seq.sv
module hbus_seq
  import hbus_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int WAIT_STATES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              held,
  input  logic              int_req,
  input  logic [ADDR_W-1:0] host_addr,
  output logic [ADDR_W-1:0] addr_q,
  output logic              xfer_n,
  output logic              ready_n,
  output logic              fire,
  output logic              host_owns,
  output logic              host_busy,
  output logic              release_now
);

  localparam int CNT_W = $clog2(WAIT_STATES + 1);

  seq_state_t       state;
  logic [CNT_W-1:0] cnt;

  assign fire        = (state == SQ_WAIT) && (cnt == CNT_W'(WAIT_STATES - 1));
  assign host_owns   = (state == SQ_WAIT);
  assign host_busy   = (state == SQ_WAIT) || (state == SQ_DONE);
  assign release_now = (state == SQ_DONE) && !held;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= SQ_IDLE;
      cnt     <= '0;
      addr_q  <= '0;
      xfer_n  <= 1'b1;
      ready_n <= 1'b1;
    end else begin
      case (state)
        SQ_IDLE: begin
          if (held) begin
            addr_q <= host_addr;
            cnt    <= '0;
            if (int_req) begin
              state <= SQ_PEND;
            end else begin
              state  <= SQ_WAIT;
              xfer_n <= 1'b0;
            end
          end
        end
        SQ_PEND: begin
          if (!int_req) begin
            state  <= SQ_WAIT;
            xfer_n <= 1'b0;
            cnt    <= '0;
          end
        end
        SQ_WAIT: begin
          if (fire) begin
            state   <= SQ_DONE;
            ready_n <= 1'b0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        SQ_DONE: begin
          if (!held) begin
            state   <= SQ_IDLE;
            xfer_n  <= 1'b1;
            ready_n <= 1'b1;
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/hbus_store.sv
module hbus_store #(
  parameter int DATA_W    = 16,
  parameter int RAM_DEPTH = 1024,
  parameter int REG_COUNT = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [$clog2(RAM_DEPTH)-1:0] ram_addr,
  input  logic                         ram_we,
  input  logic [DATA_W-1:0]            ram_wdata,
  output logic [DATA_W-1:0]            ram_q,
  input  logic [$clog2(REG_COUNT)-1:0] reg_idx,
  input  logic                         reg_we,
  input  logic [DATA_W-1:0]            reg_wdata,
  output logic [DATA_W-1:0]            reg_q
);

  // Single-port, read-first RAM with registered output (block RAM friendly)
  logic [DATA_W-1:0] mem [RAM_DEPTH];

  always_ff @(posedge clk) begin
    if (ram_we) begin
      mem[ram_addr] <= ram_wdata;
    end
    ram_q <= mem[ram_addr];
  end

  // Register file, reset to zero
  logic [DATA_W-1:0] regs [REG_COUNT];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < REG_COUNT; i++) begin
        regs[i] <= '0;
      end
    end else if (reg_we) begin
      regs[reg_idx] <= reg_wdata;
    end
  end

  assign reg_q = regs[reg_idx];

endmodule

// File: rtl/hbus_wait_if.sv
module hbus_wait_if
  import hbus_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = 16,
  parameter int RAM_DEPTH   = 1024,
  parameter int REG_COUNT   = 8,
  parameter int WAIT_STATES = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         hb_strobe_n,
  input  logic                         hb_select_n,
  input  logic                         hb_mem_nreg,
  input  logic                         hb_rw,
  input  logic                         hb_rw_pol,
  input  logic [ADDR_W-1:0]            hb_addr,
  input  logic [DATA_W-1:0]            hb_wdata,
  output logic [DATA_W-1:0]            hb_rdata,
  output logic                         hb_xfer_n,
  output logic                         hb_ready_n,
  input  logic                         int_req,
  input  logic                         int_we,
  input  logic [$clog2(RAM_DEPTH)-1:0] int_addr,
  input  logic [DATA_W-1:0]            int_wdata,
  output logic [DATA_W-1:0]            int_rdata,
  output logic                         int_gnt
);

  localparam int RAM_AW = $clog2(RAM_DEPTH);
  localparam int REG_AW = $clog2(REG_COUNT);

  logic              held;
  ctl_t              ctl;
  logic [ADDR_W-1:0] addr_q;
  logic              fire;
  logic              host_owns;
  logic              host_busy;
  logic              release_now;

  hbus_ctl_latch u_latch (
    .clk      (clk),
    .rst      (rst),
    .strobe_n (hb_strobe_n),
    .select_n (hb_select_n),
    .mem_nreg (hb_mem_nreg),
    .rw       (hb_rw),
    .rw_pol   (hb_rw_pol),
    .held     (held),
    .ctl      (ctl)
  );

  hbus_seq #(
    .ADDR_W      (ADDR_W),
    .WAIT_STATES (WAIT_STATES)
  ) u_seq (
    .clk         (clk),
    .rst         (rst),
    .held        (held),
    .int_req     (int_req),
    .host_addr   (hb_addr),
    .addr_q      (addr_q),
    .xfer_n      (hb_xfer_n),
    .ready_n     (hb_ready_n),
    .fire        (fire),
    .host_owns   (host_owns),
    .host_busy   (host_busy),
    .release_now (release_now)
  );

  // Internal requester is served unless a host transfer holds the RAM
  assign int_gnt = int_req && !host_busy;

  logic [RAM_AW-1:0] ram_addr;
  logic              ram_we;
  logic [DATA_W-1:0] ram_wdata;
  logic [DATA_W-1:0] ram_q;
  logic              reg_we;
  logic [DATA_W-1:0] reg_q;
  logic              host_wr;

  assign host_wr   = fire && !ctl.is_read;
  assign ram_addr  = host_owns ? addr_q[RAM_AW-1:0] : int_addr;
  assign ram_we    = (host_wr && ctl.to_ram) || (int_gnt && int_we);
  assign ram_wdata = host_owns ? hb_wdata : int_wdata;
  assign reg_we    = host_wr && !ctl.to_ram;

  hbus_store #(
    .DATA_W    (DATA_W),
    .RAM_DEPTH (RAM_DEPTH),
    .REG_COUNT (REG_COUNT)
  ) u_store (
    .clk       (clk),
    .rst       (rst),
    .ram_addr  (ram_addr),
    .ram_we    (ram_we),
    .ram_wdata (ram_wdata),
    .ram_q     (ram_q),
    .reg_idx   (addr_q[REG_AW-1:0]),
    .reg_we    (reg_we),
    .reg_wdata (hb_wdata),
    .reg_q     (reg_q)
  );

  assign int_rdata = ram_q;

  // Address bits above the RAM index only exist when the RAM is shallow
  if (RAM_AW < ADDR_W) begin : g_addr_hi
    logic addr_hi_unused;
    assign addr_hi_unused = ^addr_q[ADDR_W-1:RAM_AW];
  end

  // Host read data register: loaded when ready falls, cleared on release
  always_ff @(posedge clk) begin
    if (rst) begin
      hb_rdata <= '0;
    end else if (fire) begin
      hb_rdata <= ctl.is_read ? (ctl.to_ram ? ram_q : reg_q) : '0;
    end else if (release_now) begin
      hb_rdata <= '0;
    end
  end

endmodule

// File: rtl/hbus_wait_if_chk.sv
module hbus_wait_if_chk #(
  parameter int DATA_W      = 16,
  parameter int WAIT_STATES = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              hb_xfer_n,
  input logic              hb_ready_n,
  input logic [DATA_W-1:0] hb_rdata,
  input logic              int_req,
  input logic              int_gnt
);

  // Cycles since transfer-enable fell, saturating
  logic [7:0] low_cnt;

  always_ff @(posedge clk) begin
    if (rst || hb_xfer_n) begin
      low_cnt <= '0;
    end else if (low_cnt != 8'hFF) begin
      low_cnt <= low_cnt + 8'd1;
    end
  end

  // R7
  wait_window_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(hb_ready_n) |-> (low_cnt == 8'(WAIT_STATES)));

  // R7
  ready_inside_xfer_chk: assert property (@(posedge clk) disable iff (rst)
    !hb_ready_n |-> !hb_xfer_n);

  // R8
  joint_release_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(hb_xfer_n) |-> $rose(hb_ready_n));

  // R9
  int_priority_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(hb_xfer_n) |-> !$past(int_req));

  // R10
  int_stall_chk: assert property (@(posedge clk) disable iff (rst)
    !hb_xfer_n |-> !int_gnt);

  // R11
  idle_bus_zero_chk: assert property (@(posedge clk) disable iff (rst)
    hb_xfer_n |-> (hb_rdata == '0));

endmodule

bind hbus_wait_if hbus_wait_if_chk #(
  .DATA_W      (DATA_W),
  .WAIT_STATES (WAIT_STATES)
) chk_i (
  .clk        (clk),
  .rst        (rst),
  .hb_xfer_n  (hb_xfer_n),
  .hb_ready_n (hb_ready_n),
  .hb_rdata   (hb_rdata),
  .int_req    (int_req),
  .int_gnt    (int_gnt)
);

// File: tb/hbus_wait_if_tb_top.sv
module hbus_wait_if_tb_top;

  localparam int DW = 16;
  localparam int AW = 16;
  localparam int RD = 1024;
  localparam int RC = 8;
  localparam int WS = 2;
  localparam int IAW = $clog2(RD);

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           hb_strobe_n = 1'b1;
  logic           hb_select_n = 1'b1;
  logic           hb_mem_nreg = 1'b1;
  logic           hb_rw = 1'b0;
  logic           hb_rw_pol = 1'b1;
  logic [AW-1:0]  hb_addr = '0;
  logic [DW-1:0]  hb_wdata = '0;
  logic [DW-1:0]  hb_rdata;
  logic           hb_xfer_n;
  logic           hb_ready_n;
  logic           int_req = 1'b0;
  logic           int_we = 1'b0;
  logic [IAW-1:0] int_addr = '0;
  logic [DW-1:0]  int_wdata = '0;
  logic [DW-1:0]  int_rdata;
  logic           int_gnt;

  always #4 clk = ~clk;

  hbus_wait_if #(
    .DATA_W(DW), .ADDR_W(AW), .RAM_DEPTH(RD), .REG_COUNT(RC), .WAIT_STATES(WS)
  ) dut_i (
    .clk(clk), .rst(rst),
    .hb_strobe_n(hb_strobe_n), .hb_select_n(hb_select_n),
    .hb_mem_nreg(hb_mem_nreg), .hb_rw(hb_rw), .hb_rw_pol(hb_rw_pol),
    .hb_addr(hb_addr), .hb_wdata(hb_wdata), .hb_rdata(hb_rdata),
    .hb_xfer_n(hb_xfer_n), .hb_ready_n(hb_ready_n),
    .int_req(int_req), .int_we(int_we), .int_addr(int_addr),
    .int_wdata(int_wdata), .int_rdata(int_rdata), .int_gnt(int_gnt)
  );

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;
  int t_x;
  int t_r;
  int wait_nz;
  logic [DW-1:0] rd_val;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // One host transfer: late starts just after a falling edge, disturb changes
  // control and address after transfer-enable falls, sel_rel drops select.
  task automatic host_xfer(input bit to_ram, input bit rw_lvl, input bit pol,
                           input logic [AW-1:0] addr, input logic [DW-1:0] wd,
                           input bit late, input bit disturb, input bit sel_rel);
    if (late) begin
      @(negedge clk); #1;
    end else begin
      @(posedge clk); #1;
    end
    hb_mem_nreg = to_ram; hb_rw = rw_lvl; hb_rw_pol = pol;
    hb_addr = addr; hb_wdata = wd;
    hb_strobe_n = 1'b0; hb_select_n = 1'b0;
    t_x = 0;
    do begin
      @(posedge clk); #1; t_x++;
    end while (hb_xfer_n && t_x < 40);
    if (disturb) begin
      hb_rw = ~rw_lvl; hb_mem_nreg = ~to_ram; hb_addr = addr + 16'd1;
    end
    if (sel_rel) hb_select_n = 1'b1;
    wait_nz = 0; t_r = 0;
    while (hb_ready_n && t_r < 40) begin
      if (hb_rdata !== '0) wait_nz++;
      @(posedge clk); #1; t_r++;
    end
    rd_val = hb_rdata;
    chk("R11", "data bus during wait states", wait_nz, 0);
    chk("R7", "wait states to ready", t_r, WS);
    hb_strobe_n = 1'b1; hb_select_n = 1'b1;
    @(posedge clk); #1;
    chk("R8", "xfer_n after release", hb_xfer_n, 1);
    chk("R8", "ready_n after release", hb_ready_n, 1);
    chk("R11", "rdata after release", hb_rdata, 0);
  endtask

  task automatic host_wr(input bit to_ram, input logic [AW-1:0] addr,
                         input logic [DW-1:0] d);
    host_xfer(to_ram, 1'b0, 1'b1, addr, d, 1'b0, 1'b0, 1'b0);
    chk("R11", "rdata on write", rd_val, 0);
  endtask

  task automatic host_rd(input bit to_ram, input logic [AW-1:0] addr,
                         input logic [DW-1:0] exp, input string req);
    host_xfer(to_ram, 1'b1, 1'b1, addr, '0, 1'b0, 1'b0, 1'b0);
    chk(req, "read data", rd_val, exp);
  endtask

  task automatic test_reset();
    chk("R1", "reset xfer_n", hb_xfer_n, 1);
    chk("R1", "reset ready_n", hb_ready_n, 1);
    chk("R1", "reset rdata", hb_rdata, 0);
    chk("R9", "reset int_gnt", int_gnt, 0);
  endtask

  task automatic test_ram_rw();
    host_wr(1'b1, 16'h0010, 16'hA5A5);
    chk("R1", "edges to xfer on timely strobe", t_x, 1);
    host_rd(1'b1, 16'h0010, 16'hA5A5, "R7");
  endtask

  task automatic test_reg_vs_ram();
    host_wr(1'b0, 16'h0003, 16'h1111);
    host_wr(1'b1, 16'h0003, 16'h2222);
    host_rd(1'b0, 16'h000B, 16'h1111, "R3");
    host_rd(1'b1, 16'h0003, 16'h2222, "R3");
    host_rd(1'b1, 16'(RD + 3), 16'h2222, "R3");
  endtask

  task automatic test_polarity();
    host_xfer(1'b1, 1'b1, 1'b0, 16'h0020, 16'h3C3C, 1'b0, 1'b0, 1'b0);
    chk("R6", "pol0 high level writes (bus zero)", rd_val, 0);
    host_xfer(1'b1, 1'b0, 1'b0, 16'h0020, 16'h0000, 1'b0, 1'b0, 1'b0);
    chk("R6", "pol0 low level reads", rd_val, 16'h3C3C);
  endtask

  task automatic test_late_strobe();
    host_xfer(1'b1, 1'b1, 1'b1, 16'h0020, 16'h0000, 1'b1, 1'b0, 1'b0);
    chk("R2", "edges to xfer on late strobe", t_x, 2);
    chk("R2", "late read data", rd_val, 16'h3C3C);
  endtask

  task automatic test_latch_hold();
    host_wr(1'b1, 16'h0031, 16'h0101);
    host_xfer(1'b1, 1'b0, 1'b1, 16'h0030, 16'h7777, 1'b0, 1'b1, 1'b0);
    chk("R4", "disturbed write kept as write", rd_val, 0);
    host_rd(1'b1, 16'h0030, 16'h7777, "R5");
    host_rd(1'b1, 16'h0031, 16'h0101, "R5");
    host_rd(1'b0, 16'h0000, 16'h0000, "R4");
  endtask

  task automatic test_select_release();
    host_xfer(1'b1, 1'b0, 1'b1, 16'h0050, 16'h5A5A, 1'b0, 1'b0, 1'b1);
    host_rd(1'b1, 16'h0050, 16'h5A5A, "R8");
  endtask

  task automatic test_int_priority();
    @(posedge clk); #1;
    int_req = 1'b1; int_we = 1'b0; int_addr = IAW'(5);
    hb_mem_nreg = 1'b1; hb_rw = 1'b1; hb_rw_pol = 1'b1; hb_addr = 16'h0010;
    hb_strobe_n = 1'b0; hb_select_n = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); #1;
      chk("R9", "host held off by internal request", hb_xfer_n, 1);
      chk("R9", "internal granted", int_gnt, 1);
    end
    int_req = 1'b0;
    @(posedge clk); #1;
    chk("R9", "xfer after internal idle", hb_xfer_n, 0);
    int_req = 1'b1;
    #1;
    chk("R10", "internal stalled during transfer", int_gnt, 0);
    t_r = 0;
    while (hb_ready_n && t_r < 40) begin
      @(posedge clk); #1; t_r++;
    end
    chk("R7", "ready after arbitration", t_r, WS);
    chk("R7", "read data after arbitration", hb_rdata, 16'hA5A5);
    chk("R10", "internal stalled while ready low", int_gnt, 0);
    hb_strobe_n = 1'b1; hb_select_n = 1'b1;
    @(posedge clk); #1;
    chk("R9", "internal resumes after release", int_gnt, 1);
    int_req = 1'b0;
  endtask

  task automatic test_int_access();
    @(posedge clk); #1;
    int_req = 1'b1; int_we = 1'b1; int_addr = IAW'(16'h0040); int_wdata = 16'hBEEF;
    @(posedge clk); #1;
    int_we = 1'b0;
    @(posedge clk); #1;
    chk("R12", "internal read back", int_rdata, 16'hBEEF);
    int_addr = IAW'(16'h0010);
    @(posedge clk); #1;
    chk("R12", "internal reads host data", int_rdata, 16'hA5A5);
    int_req = 1'b0;
    host_rd(1'b1, 16'h0040, 16'hBEEF, "R12");
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(posedge clk); #1;
    test_reset();
    test_ram_rw();
    test_reg_vs_ram();
    test_polarity();
    test_late_strobe();
    test_latch_hold();
    test_select_release();
    test_int_priority();
    test_int_access();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  end

endmodule